// File: doc/BRIEF.md
# Self-Correcting Periodic Interrupt Timer

This block is an 8-bit up-counter that advances on every clock and raises an interrupt request when it rolls over from 255 to 0. The counter does not stop when the interrupt is taken. It keeps counting through handler entry, the handler body and the return. When the handler finishes, it holds the number of cycles spent since the rollover.

The return strobe does not load the counter. It adds its signed 8-bit operand to the live count. A handler that returns with an operand of minus N therefore gets its next interrupt exactly N cycles after the previous one, whatever its own run time was, provided the whole handler fits inside N. A second atomic add port lets software reload the timer without interrupts. In that mode software polls count bit 7 or a sticky overflow flag.

There is a single interrupt level. A rollover that happens while the handler is running is held and presented again as soon as the handler returns.

Top module: `selfcorr_timer`

## Requirements
- R1: After reset, the count is 0, the overflow flag is 0 and the interrupt request is low.
- R2: With no add strobe, the count advances by exactly one per clock and wraps from 255 to 0.
- R3: A cycle in which the count is 255 is a rollover. On the next cycle the rollover becomes a pending request if the interrupt enable was high. The interrupt request output equals pending AND enable AND NOT in-handler.
- R4: The return strobe makes the next count equal to count + 1 + operand, modulo 256. The operand is in two's complement. The return strobe also ends the in-handler state.
- R5: The plain add strobe makes the next count equal to count + 1 + operand, modulo 256, so no tick is lost. When it coincides with a return strobe, both operands are added.
- R6: When each handler returns with operand 256 − N, consecutive rising edges of the interrupt request are exactly N cycles apart. This holds for any handler length below N.
- R7: The overflow flag is set on the cycle after every rollover and stays set until the clear strobe. A rollover that coincides with a clear leaves the flag set.
- R8: A rollover that occurs in the handler is not lost. The interrupt request rises on the cycle after the return strobe.
- R9: While the enable is low, the counter runs, the flag still sets and the request stays low. Rollovers seen while the enable is low are not recorded as pending.
- R10: The output `countMsb` is bit 7 of the count, for polled use.
- R11: An acknowledge strobe while the request is low has no effect. It does not enter the handler and does not mask a later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| intEnable | input | 1 | Interrupt enable |
| intAck | input | 1 | Handler-entry strobe; taken only while intReq is high |
| retStrobe | input | 1 | Return-with-add strobe |
| retOperand | input | 8 | Value added to the count on return |
| wrStrobe | input | 1 | Plain atomic add strobe |
| wrOperand | input | 8 | Value added to the count by wrStrobe |
| ovfClear | input | 1 | Clears the sticky overflow flag |
| intReq | output | 1 | Interrupt request |
| count | output | 8 | Current count |
| countMsb | output | 1 | Bit 7 of the count |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The first pattern is a free run with the enable low. It separates plain counting and flag behaviour from the interrupt path. Atomic adds, alone and together with a return, show whether a tick is lost when an add meets an increment. Handlers of three different lengths all return with the same minus-N operand, and the intervals between requests are measured. This exposes any design that loads the operand instead of adding it. A handler deliberately held longer than the period, and a flag clear timed onto the rollover cycle, probe the pending hold and the set-wins priority.

// File: rtl/selfcorr_timer_pkg.sv
package selfcorr_timer_pkg;
  localparam int TMR_W = 8;

  // Strobes from control to datapath each cycle
  typedef struct packed {
    logic [TMR_W-1:0] addVal;   // summed operand, zero when no add
    logic             flagClr;
  } tmrCtl_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import selfcorr_timer_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmrCtl_t      ctl,
  output logic [W-1:0] count,
  output logic         wrapNow,
  output logic         ovfFlag
);
  localparam logic [W-1:0] MAX_CNT = {W{1'b1}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  assign wrapNow = (count == MAX_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      count <= count + ONE + ctl.addVal;
      if (wrapNow)          ovfFlag <= 1'b1;
      else if (ctl.flagClr) ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import selfcorr_timer_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         intEnable,
  input  logic         intAck,
  input  logic         retStrobe,
  input  logic [W-1:0] retOperand,
  input  logic         wrStrobe,
  input  logic [W-1:0] wrOperand,
  input  logic         ovfClear,
  input  logic         wrapNow,
  output tmrCtl_t      ctl,
  output logic         intReq
);
  logic pending;
  logic inService;
  logic taken;

  assign intReq = pending & intEnable & ~inService;
  assign taken  = intReq & intAck;

  always_comb begin
    ctl.addVal  = (retStrobe ? retOperand : '0) + (wrStrobe ? wrOperand : '0);
    ctl.flagClr = ovfClear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      inService <= 1'b0;
    end else begin
      pending <= (pending & ~taken) | (wrapNow & intEnable);
      if (taken)          inService <= 1'b1;
      else if (retStrobe) inService <= 1'b0;
    end
  end
endmodule

// File: rtl/selfcorr_timer.sv
module selfcorr_timer
  import selfcorr_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             intEnable,
  input  logic             intAck,
  input  logic             retStrobe,
  input  logic [TMR_W-1:0] retOperand,
  input  logic             wrStrobe,
  input  logic [TMR_W-1:0] wrOperand,
  input  logic             ovfClear,
  output logic             intReq,
  output logic [TMR_W-1:0] count,
  output logic             countMsb,
  output logic             ovfFlag
);
  tmrCtl_t ctl;
  logic    wrapNow;

  tmr_control #(.W(TMR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .intEnable(intEnable), .intAck(intAck),
    .retStrobe(retStrobe), .retOperand(retOperand),
    .wrStrobe(wrStrobe), .wrOperand(wrOperand), .ovfClear(ovfClear),
    .wrapNow(wrapNow), .ctl(ctl), .intReq(intReq)
  );

  tmr_datapath #(.W(TMR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .count(count), .wrapNow(wrapNow), .ovfFlag(ovfFlag)
  );

  assign countMsb = count[TMR_W-1];
endmodule

// File: rtl/selfcorr_timer_chk.sv
module selfcorr_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         intEnable,
  input logic         intAck,
  input logic         retStrobe,
  input logic [W-1:0] retOperand,
  input logic         wrStrobe,
  input logic [W-1:0] wrOperand,
  input logic         ovfClear,
  input logic         intReq,
  input logic [W-1:0] count,
  input logic         ovfFlag
);
  localparam logic [W-1:0] MAX_CNT = {W{1'b1}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic seenClk;
  always_ff @(posedge clk) seenClk <= rstN;

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN || !seenClk)
    (!retStrobe && !wrStrobe) |=> count == $past(count) + ONE);

  p_ret_add_r4: assert property (@(posedge clk) disable iff (!rstN || !seenClk)
    (retStrobe && !wrStrobe) |=> count == $past(count) + ONE + $past(retOperand));

  p_wr_add_r5: assert property (@(posedge clk) disable iff (!rstN || !seenClk)
    (wrStrobe && !retStrobe) |=> count == $past(count) + ONE + $past(wrOperand));

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rstN || !seenClk)
    (count == MAX_CNT) |=> ovfFlag);

  p_single_level_r8: assert property (@(posedge clk) disable iff (!rstN || !seenClk)
    (intReq && intAck && !retStrobe) |=> !intReq);

  p_no_req_disabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> !intReq);
endmodule

bind selfcorr_timer selfcorr_timer_chk #(.W(selfcorr_timer_pkg::TMR_W)) u_chk (
  .clk(clk), .rstN(rstN), .intEnable(intEnable), .intAck(intAck),
  .retStrobe(retStrobe), .retOperand(retOperand), .wrStrobe(wrStrobe),
  .wrOperand(wrOperand), .ovfClear(ovfClear), .intReq(intReq),
  .count(count), .ovfFlag(ovfFlag)
);

// File: tb/selfcorr_timer_test.sv
`timescale 1ns/1ps
module selfcorr_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intEnable = 1'b0, intAck = 1'b0, retStrobe = 1'b0, wrStrobe = 1'b0, ovfClear = 1'b0;
  logic [7:0] retOperand = 8'd0, wrOperand = 8'd0;
  logic intReq, countMsb, ovfFlag;
  logic [7:0] count;

  always #2.5 clk = ~clk;

  selfcorr_timer uut (
    .clk(clk), .rstN(rstN), .intEnable(intEnable), .intAck(intAck),
    .retStrobe(retStrobe), .retOperand(retOperand), .wrStrobe(wrStrobe),
    .wrOperand(wrOperand), .ovfClear(ovfClear), .intReq(intReq),
    .count(count), .countMsb(countMsb), .ovfFlag(ovfFlag)
  );

  int vecs = 0;
  int errs = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference
  int mCnt = 0;
  bit mFlag = 0, mPend = 0, mSvc = 0;

  always @(posedge clk) begin
    int addv;
    bit ovf, take;
    cyc++;
    if (!rstN) begin
      mCnt = 0; mFlag = 0; mPend = 0; mSvc = 0;
    end else begin
      ovf  = (mCnt == 255);
      take = mPend && intEnable && !mSvc && intAck;
      addv = 0;
      if (retStrobe) addv += retOperand;
      if (wrStrobe)  addv += wrOperand;
      mCnt = (mCnt + 1 + addv) % 256;
      if (ovf) mFlag = 1; else if (ovfClear) mFlag = 0;
      mPend = (mPend && !take) || (ovf && intEnable);
      if (take) mSvc = 1; else if (retStrobe) mSvc = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk(count == 8'(mCnt), "R2 R4 R5 count", count, mCnt);
      chk(ovfFlag == mFlag, "R7 flag", ovfFlag, mFlag);
      chk(intReq == (mPend && intEnable && !mSvc), "R3 R8 R9 R11 intReq",
          intReq, int'(mPend && intEnable && !mSvc));
      chk(countMsb == 1'(mCnt >> 7), "R10 msb", countMsb, mCnt >> 7);
    end
  end

  // request rise times
  int rises[$];
  logic lastReq = 1'b0;
  always @(negedge clk) begin
    #1;
    if (intReq && !lastReq) rises.push_back(cyc);
    lastReq = intReq;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitReq();
    for (int i = 0; i < 1000 && !intReq; i++) begin
      @(negedge clk); #1;
    end
  endtask

  // handler: 3-cycle entry, body, return with -n
  task automatic serve(input int body, input int n);
    waitReq();
    @(negedge clk); intAck = 1'b1;
    #1; // still same cycle; ack held one clock
    @(negedge clk); intAck = 1'b0;
    tick(1 + body);
    retStrobe = 1'b1; retOperand = 8'(256 - n);
    @(negedge clk); retStrobe = 1'b0; retOperand = 8'd0;
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int c0;
    tick(3); #1;
    // R1 reset state
    chk(count == 0 && ovfFlag == 0 && intReq == 0, "R1 reset", count, 0);
    @(negedge clk); rstN = 1'b1;

    // R2 R9 free run, enable low
    tick(300); #1;
    chk(ovfFlag == 1, "R9 flag sets with enable low", ovfFlag, 1);
    chk(intReq == 0, "R9 no request with enable low", intReq, 0);
    // R11 stray ack
    @(negedge clk); intAck = 1'b1; @(negedge clk); intAck = 1'b0;
    // R7 clear
    ovfClear = 1'b1; @(negedge clk); ovfClear = 1'b0; #1;
    chk(ovfFlag == 0 || count == 0, "R7 clear", ovfFlag, 0);

    // R5 atomic add alone
    @(negedge clk); #1; c0 = count;
    wrStrobe = 1'b1; wrOperand = 8'hF6;
    @(negedge clk); wrStrobe = 1'b0; #1;
    chk(count == 8'(c0 + 1 - 10), "R5 atomic add", count, (c0 + 1 - 10) & 255);

    // R5 add and return together
    @(negedge clk); #1; c0 = count;
    wrStrobe = 1'b1; wrOperand = 8'd5; retStrobe = 1'b1; retOperand = 8'd7;
    @(negedge clk); wrStrobe = 1'b0; retStrobe = 1'b0; #1;
    chk(count == 8'(c0 + 13), "R5 coincident adds", count, (c0 + 13) & 255);

    // R7 clear on rollover cycle: set wins
    for (int i = 0; i < 300 && count != 8'hFF; i++) begin @(negedge clk); #1; end
    ovfClear = 1'b1; @(negedge clk); ovfClear = 1'b0; #1;
    chk(ovfFlag == 1, "R7 set wins over clear", ovfFlag, 1);

    // R6 exact period with varying handler lengths
    intEnable = 1'b1;
    serve(2, 60);
    rises.delete();
    serve(5, 60); serve(20, 60); serve(40, 60); serve(10, 60);
    waitReq();
    chk(rises.size() >= 4, "R6 rises seen", rises.size(), 4);
    for (int i = 1; i < rises.size(); i++)
      chk(rises[i] - rises[i-1] == 60, "R6 period", rises[i] - rises[i-1], 60);

    // R8 overflow during handler held pending
    @(negedge clk); intAck = 1'b1; @(negedge clk); intAck = 1'b0;
    tick(300); #1;
    chk(intReq == 0, "R8 masked in handler", intReq, 0);
    @(negedge clk); retStrobe = 1'b1; retOperand = 8'd0;
    @(negedge clk); retStrobe = 1'b0; #1;
    chk(intReq == 1, "R8 request after return", intReq, 1);
    serve(1, 100);
    tick(20);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule